// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Trap

This block is the integer datapath of a load/store RISC core's execute stage. It is purely combinational. It takes two register operands, a 16-bit instruction immediate, a 5-bit constant shift amount and an operation code. It returns a 32-bit result and a trap flag within the same cycle. The surrounding pipeline decides what to do with the result and with the trap. The block never writes registers itself.

Addition and subtraction come in two flavours. The signed forms raise the trap when the two's-complement result cannot be represented. The unsigned forms return the wrapped value and stay quiet. Each immediate form extends its 16-bit field in the way its operation needs: arithmetic and compare forms sign-extend it, and logic forms zero-extend it. Multiply and divide belong elsewhere.

Top module: `alu_int_exec`

## Requirements
- R1: For ADD (0), SUB (2) and ADDI (4), `ovf_trap` is 1 exactly when the signed result overflows. Addition overflows when both operands share a sign and the sum's sign differs from it. Subtraction overflows when the operand signs differ and the difference's sign differs from `src_a`. `result` carries the wrapped value either way.
- R2: ADDU (1), SUBU (3) and ADDIU (5) return the 32-bit wrapped sum or difference and never set `ovf_trap`.
- R3: ADDI, ADDIU, SLTI (15) and SLTIU (16) use `imm` sign-extended to 32 bits as the second operand. SLTIU still compares unsigned after the extension.
- R4: ANDI (10), ORI (11) and XORI (12) use `imm` zero-extended to 32 bits, combined with `src_a`.
- R5: AND (6), OR (7), XOR (8) and NOR (9) combine `src_a` with `src_b` bitwise.
- R6: SLT (13) compares signed and SLTU (14) compares unsigned, testing `src_a` < `src_b`. The result is 1 or 0 in bit 0, with all other bits 0.
- R7: SLL (17), SRL (18) and SRA (19) shift `src_b` by `shamt`. SRL fills with zeros and SRA fills with the sign bit.
- R8: SLLV (20), SRLV (21) and SRAV (22) shift `src_b` by `src_a[4:0]`. The upper bits of `src_a` and the `shamt` port have no effect on these operations.
- R9: LUI (23) places `imm` in bits 31:16 and zeros in bits 15:0.
- R10: Both outputs depend only on the present inputs and settle within the same cycle. There is no state.
- R11: Codes 24 to 31 are unused and give a `result` of 0 and an `ovf_trap` of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (values in R1 to R11) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Instruction immediate field |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow exception request |

## Verification
Every result and the trap flag are due in the same cycle as the stimulus, with zero register stages. The bench drives each operand set and waits one time unit for the combinational logic to settle. It then compares both outputs against constants worked out by hand from the requirements. Each check drives inputs away from the clock edge and samples within that same time step, so no check depends on clock ordering.

// File: rtl/alu_int_pkg.sv
// Package: operation codes shared by the execution unit and its parts.
// Assumes a 5-bit operation select; codes 24..31 are unused.
package alu_int_pkg;
    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
        OP_ADDI  = 5'd4,  OP_ADDIU = 5'd5,  OP_AND   = 5'd6,  OP_OR    = 5'd7,
        OP_XOR   = 5'd8,  OP_NOR   = 5'd9,  OP_ANDI  = 5'd10, OP_ORI   = 5'd11,
        OP_XORI  = 5'd12, OP_SLT   = 5'd13, OP_SLTU  = 5'd14, OP_SLTI  = 5'd15,
        OP_SLTIU = 5'd16, OP_SLL   = 5'd17, OP_SRL   = 5'd18, OP_SRA   = 5'd19,
        OP_SLLV  = 5'd20, OP_SRLV  = 5'd21, OP_SRAV  = 5'd22, OP_LUI   = 5'd23
    } alu_op_e;
endpackage

// File: rtl/alu_opnd_sel.sv
// Second-operand selector: chooses src_b, the sign-extended immediate or
// the zero-extended immediate according to the operation.
// Assumes DATA_W > IMM_W.
module alu_opnd_sel
    import alu_int_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [IMM_W-1:0]    imm,
    output logic [DATA_W-1:0]   opnd_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] imm_zx;

    // Build both extensions of the immediate.
    always_comb begin
        imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
        imm_zx = {{EXT_W{1'b0}}, imm};
    end

    // Pick the operand each operation expects (R3, R4).
    always_comb begin
        unique case (op)
            OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU: opnd_b = imm_sx;
            OP_ANDI, OP_ORI, OP_XORI:             opnd_b = imm_zx;
            default:                              opnd_b = src_b;
        endcase
    end

    // R4: logic-immediate operands never carry bits above the field.
    always_comb begin
        if (op == OP_ANDI || op == OP_ORI || op == OP_XORI)
            assert_zext_hi_R4: assert (opnd_b[DATA_W-1:IMM_W] == '0);
    end
endmodule

// File: rtl/alu_addsub.sv
// Shared adder/subtractor with a raw signed-overflow indication.
// Assumes the caller decides whether the overflow is reported.
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_raw
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opb_eff;

    // Add, or add the inverted operand plus one for subtraction.
    always_comb begin
        opb_eff = do_sub ? ~opb : opb;
        sum     = opa + opb_eff + {{(DATA_W-1){1'b0}}, do_sub};
        ovf_raw = (opa[MSB] == opb_eff[MSB]) && (sum[MSB] != opa[MSB]);
    end

    // R1: an addition of operands with opposite signs cannot overflow.
    always_comb begin
        if (!do_sub && (opa[MSB] != opb[MSB]))
            assert_add_mixed_sign_R1: assert (!ovf_raw);
    end
endmodule

// File: rtl/alu_shifter.sv
// Barrel shifter: logical left, logical right and arithmetic right.
// Assumes the amount has already been chosen (constant or register).
module alu_shifter #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val,
    input  logic [SH_W-1:0]   amt,
    input  logic [1:0]        kind,   // 0 left, 1 logical right, 2 arithmetic right
    output logic [DATA_W-1:0] shifted
);
    // Apply the selected shift.
    always_comb begin
        unique case (kind)
            2'd0:    shifted = val << amt;
            2'd1:    shifted = val >> amt;
            default: shifted = $unsigned($signed(val) >>> amt);
        endcase
    end

    // R7: a zero amount passes the value through unchanged.
    always_comb begin
        if (amt == '0)
            assert_zero_shift_R7: assert (shifted == val);
    end
endmodule

// File: rtl/alu_int_exec.sv
// Integer execution unit: arithmetic, logic, compare, shift and
// upper-immediate load in one combinational pass, with a trap for signed
// overflow on the signed add/subtract forms. Assumes no state and no reset.
module alu_int_exec
    import alu_int_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [4:0]         op_sel,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [IMM_W-1:0]   imm,
    input  logic [SH_W-1:0]    shamt,
    output logic [DATA_W-1:0]  result,
    output logic               ovf_trap
);
    localparam int LO_W = DATA_W - IMM_W;

    alu_op_e           op;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] sum;
    logic              ovf_raw;
    logic              do_sub;
    logic [SH_W-1:0]   sh_amt;
    logic [1:0]        sh_kind;
    logic [DATA_W-1:0] shifted;
    logic              lt_s;
    logic              lt_u;

    // Decode the select into the enumerated operation.
    always_comb op = alu_op_e'(op_sel);

    alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .op(op), .src_b(src_b), .imm(imm), .opnd_b(opnd_b)
    );

    // Subtract for the two subtract codes only.
    always_comb do_sub = (op == OP_SUB) || (op == OP_SUBU);

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .opa(src_a), .opb(opnd_b), .do_sub(do_sub), .sum(sum), .ovf_raw(ovf_raw)
    );

    // Choose shift amount source and shift kind (R7, R8).
    always_comb begin
        unique case (op)
            OP_SLLV, OP_SRLV, OP_SRAV: sh_amt = src_a[SH_W-1:0];
            default:                   sh_amt = shamt;
        endcase
        unique case (op)
            OP_SRL, OP_SRLV: sh_kind = 2'd1;
            OP_SRA, OP_SRAV: sh_kind = 2'd2;
            default:         sh_kind = 2'd0;
        endcase
    end

    alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .val(src_b), .amt(sh_amt), .kind(sh_kind), .shifted(shifted)
    );

    // Signed and unsigned less-than against the selected operand (R6, R3).
    always_comb begin
        lt_s = $signed(src_a) < $signed(opnd_b);
        lt_u = src_a < opnd_b;
    end

    // Result multiplexer over all operations (R1..R11).
    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
            OP_ADDI, OP_ADDIU:            result = sum;
            OP_AND, OP_ANDI:              result = src_a & opnd_b;
            OP_OR, OP_ORI:                result = src_a | opnd_b;
            OP_XOR, OP_XORI:              result = src_a ^ opnd_b;
            OP_NOR:                       result = ~(src_a | opnd_b);
            OP_SLT, OP_SLTI:              result = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU, OP_SLTIU:            result = {{(DATA_W-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV, OP_SRAV:    result = shifted;
            OP_LUI:                       result = {imm, {LO_W{1'b0}}};
            default:                      result = '0;
        endcase
    end

    // Report overflow only for the signed arithmetic forms (R1, R2).
    always_comb ovf_trap = ovf_raw && (op == OP_ADD || op == OP_SUB || op == OP_ADDI);

    // R2: unsigned forms never trap.
    always_comb begin
        if (op == OP_ADDU || op == OP_SUBU || op == OP_ADDIU)
            assert_no_overflow_R2: assert (!ovf_trap);
    end

    // R6: compare operations give a single-bit truth value.
    always_comb begin
        if (op == OP_SLT || op == OP_SLTU || op == OP_SLTI || op == OP_SLTIU)
            assert_compare_bit_R6: assert (result[DATA_W-1:1] == '0);
    end

    // R9: upper-immediate load clears the low half.
    always_comb begin
        if (op == OP_LUI)
            assert_lui_low_R9: assert (result[LO_W-1:0] == '0);
    end

    // R11: unused codes are inert.
    always_comb begin
        if (op_sel > 5'd23)
            assert_unused_code_R11: assert (result == '0 && !ovf_trap);
    end
endmodule

// File: tb/alu_int_exec_tb.sv
// Directed bench: one task per scenario, expected values worked out by hand.
module alu_int_exec_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf_trap;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_int_exec dut_i (
        .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm(imm),
        .shamt(shamt), .result(result), .ovf_trap(ovf_trap)
    );

    // Drive away from the rising edge, let logic settle, compare both outputs.
    task automatic apply(input string req, input logic [4:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] im, input logic [4:0] sh,
                         input logic [31:0] exp_res, input logic exp_trap);
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; imm = im; shamt = sh;
        #1;
        checks++;
        if (result !== exp_res || ovf_trap !== exp_trap) begin
            errors++;
            $display("FAIL %s op=%0d result=%h trap=%b expected result=%h trap=%b",
                     req, op, result, ovf_trap, exp_res, exp_trap);
        end
    endtask

    task automatic t_idle();
        apply("R10", 5'd0, 32'h0, 32'h0, 16'h0, 5'd0, 32'h0, 1'b0);
        apply("R10", 5'd0, 32'd3, 32'd4, 16'h0, 5'd0, 32'd7, 1'b0);
    endtask

    task automatic t_signed_trap();
        apply("R1", 5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h8000_0000, 1'b1);
        apply("R1", 5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 5'd0, 32'h7FFF_FFFF, 1'b1);
        apply("R1", 5'd2, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 32'h7FFF_FFFF, 1'b1);
        apply("R1", 5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0, 32'h8000_0000, 1'b1);
        apply("R1", 5'd2, 32'd5, 32'd9, 16'h0, 5'd0, 32'hFFFF_FFFC, 1'b0);
        apply("R1", 5'd4, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0, 32'h8000_0000, 1'b1);
        apply("R1", 5'd0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_unsigned_wrap();
        apply("R2", 5'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h8000_0000, 1'b0);
        apply("R2", 5'd1, 32'hFFFF_FFFF, 32'h2, 16'h0, 5'd0, 32'h1, 1'b0);
        apply("R2", 5'd3, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 32'h7FFF_FFFF, 1'b0);
        apply("R2", 5'd5, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0, 32'h8000_0000, 1'b0);
    endtask

    task automatic t_imm_ext();
        apply("R3", 5'd4, 32'd5, 32'h0, 16'hFFFF, 5'd0, 32'd4, 1'b0);
        apply("R3", 5'd15, 32'hFFFF_FFFB, 32'h0, 16'hFFFF, 5'd0, 32'd1, 1'b0);
        apply("R3", 5'd16, 32'd5, 32'h0, 16'hFFFF, 5'd0, 32'd1, 1'b0);
        apply("R3", 5'd16, 32'hFFFF_FFFF, 32'h0, 16'h0005, 5'd0, 32'd0, 1'b0);
        apply("R4", 5'd10, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0, 32'h0000_8001, 1'b0);
        apply("R4", 5'd11, 32'h1234_0000, 32'h0, 16'hF00F, 5'd0, 32'h1234_F00F, 1'b0);
        apply("R4", 5'd12, 32'hFFFF_FFFF, 32'h0, 16'h8000, 5'd0, 32'hFFFF_7FFF, 1'b0);
    endtask

    task automatic t_logic();
        apply("R5", 5'd6, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 5'd0, 32'hF000_1200, 1'b0);
        apply("R5", 5'd7, 32'hF0F0_0000, 32'h0F00_0001, 16'h0, 5'd0, 32'hFFF0_0001, 1'b0);
        apply("R5", 5'd8, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 5'd0, 32'h5555_5555, 1'b0);
        apply("R5", 5'd9, 32'h0000_00F0, 32'h0000_000F, 16'h0, 5'd0, 32'hFFFF_FF00, 1'b0);
    endtask

    task automatic t_compare();
        apply("R6", 5'd13, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'd1, 1'b0);
        apply("R6", 5'd14, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'd0, 1'b0);
        apply("R6", 5'd13, 32'd7, 32'd7, 16'h0, 5'd0, 32'd0, 1'b0);
        apply("R6", 5'd14, 32'd1, 32'h8000_0000, 16'h0, 5'd0, 32'd1, 1'b0);
    endtask

    task automatic t_shifts();
        apply("R7", 5'd17, 32'h0, 32'h1, 16'h0, 5'd31, 32'h8000_0000, 1'b0);
        apply("R7", 5'd18, 32'h0, 32'h8000_0000, 16'h0, 5'd4, 32'h0800_0000, 1'b0);
        apply("R7", 5'd19, 32'h0, 32'h8000_0000, 16'h0, 5'd4, 32'hF800_0000, 1'b0);
        apply("R7", 5'd19, 32'h0, 32'h4000_0000, 16'h0, 5'd4, 32'h0400_0000, 1'b0);
        apply("R8", 5'd20, 32'h0000_0021, 32'h3, 16'h0, 5'd9, 32'h6, 1'b0);
        apply("R8", 5'd21, 32'hFFFF_FFE4, 32'h100, 16'h0, 5'd0, 32'h10, 1'b0);
        apply("R8", 5'd22, 32'h0000_003F, 32'h8000_0000, 16'h0, 5'd1, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_lui_unused();
        apply("R9", 5'd23, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, 5'd0, 32'hABCD_0000, 1'b0);
        apply("R11", 5'd24, 32'h7FFF_FFFF, 32'h1, 16'hFFFF, 5'd3, 32'h0, 1'b0);
        apply("R11", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, 32'h0, 1'b0);
    endtask

    initial begin
        t_idle();
        t_signed_trap();
        t_unsigned_wrap();
        t_imm_ext();
        t_logic();
        t_compare();
        t_shifts();
        t_lui_unused();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule